// File: doc/BRIEF.md
# Embedded Logic Analyzer Trigger Core

This block is an on-chip capture engine for debugging a chip in place. It records a probe bus into a circular sample buffer on every qualified cycle of its sample clock. It also watches that same bus for a programmable trigger condition. After the trigger it records a programmable number of further samples. It then freezes the buffer, so a host tool can read it at any later time, even long after the event.

Arming is controlled by an external run input. The input can be tied to a level that is valid right after power-up, so the core catches events that happen before any debug software attaches. Several trigger units each compare a masked slice of the probe bus with a programmed value, in equal or not-equal mode. A single expression combines two selected unit results. The expression can be AND, OR or XOR, each operand with an optional inversion, or a two-step sequence in which the first operand must be seen before the core waits for the second. A one-cycle re-arm pulse starts a new capture.

Top module: `la_trigger_core`

## Requirements
- R1: After synchronous reset, `done` and `triggered` are 0, `trig_addr` is 0 and the write pointer is at address 0.
- R2: While `trig_en` is 0, no trigger can fire and the sequence step does not advance. Samples are still written to the buffer.
- R3: Trigger unit u hits when `((probe ^ value_u) & mask_u) == 0`. If its bit in `tu_ne` is 1, the result is inverted. Unit u uses bits [u*PROBE_W +: PROBE_W] of `tu_value` and `tu_mask`.
- R4: With `expr_op` 0 (AND), 1 (OR) or 2 (XOR), the trigger fires on a qualified sample when the named operation of A and B is true. A is unit `sel_a` XOR `inv_a`, and B is unit `sel_b` XOR `inv_b`.
- R5: With `expr_op` 3 (THEN), the first qualified sample with A true latches the first step and does not trigger, even if B is also true. The trigger fires on a later qualified sample with B true.
- R6: A cycle with `sample_en` 0 writes nothing, does not advance the write pointer and is not evaluated for the trigger.
- R7: The trigger sample is stored at `trig_addr`. Exactly `post_len` further qualified samples are written. Then `done` rises on the edge that stores the last of them. With `post_len` 0, `done` rises on the trigger edge.
- R8: Once `done` is 1, the buffer contents, `trig_addr` and `done` hold until a re-arm. `rd_data` returns the entry at `rd_addr` one clock after the address is presented.
- R9: A `rearm` pulse clears `done`, `triggered` and the sequence step on the next edge. It writes nothing, and the write pointer keeps its value.
- R10: The write pointer wraps from DEPTH-1 to 0, so the buffer always holds the most recent DEPTH samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_en | input | 1 | Run input; trigger search active while 1 |
| sample_en | input | 1 | Qualifies the current cycle as a sample |
| rearm | input | 1 | One-cycle pulse starting a new capture |
| probe | input | PROBE_W | Probe bus being observed |
| tu_value | input | NUM_UNITS*PROBE_W | Compare values, one slice per unit |
| tu_mask | input | NUM_UNITS*PROBE_W | Compare masks, one slice per unit |
| tu_ne | input | NUM_UNITS | Per-unit not-equal mode |
| expr_op | input | 2 | 0 AND, 1 OR, 2 XOR, 3 THEN |
| sel_a | input | log2(NUM_UNITS) | Unit feeding operand A |
| sel_b | input | log2(NUM_UNITS) | Unit feeding operand B |
| inv_a | input | 1 | Invert operand A |
| inv_b | input | 1 | Invert operand B |
| post_len | input | log2(DEPTH) | Samples captured after the trigger |
| rd_addr | input | log2(DEPTH) | Buffer read address |
| rd_data | output | PROBE_W | Buffer read data, one cycle latency |
| done | output | 1 | Capture complete, buffer frozen |
| triggered | output | 1 | Trigger has fired since the last re-arm |
| trig_addr | output | log2(DEPTH) | Buffer address of the trigger sample |

## Verification
The assertions assume a few things about the inputs. `rearm` is a single-cycle pulse. `expr_op` and the selectors are not changed between a qualified sample and the edge that evaluates it. The buffer is read only while `sample_en` is low. The stimulus drives every input on the falling edge and changes trigger configuration only in the quiet cycles around a re-arm. Each readback is done with `sample_en`, `trig_en` and `rearm` held at 0, so no sample or sequence step can slip in during a read.

// File: rtl/la_pkg.sv
package la_pkg;
  typedef enum logic [1:0] {
    OP_AND  = 2'd0,
    OP_OR   = 2'd1,
    OP_XOR  = 2'd2,
    OP_THEN = 2'd3
  } expr_op_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_POST = 2'd1,
    ST_DONE = 2'd2
  } cap_state_e;
endpackage

// File: rtl/la_trig_unit.sv
module la_trig_unit #(
  parameter int PROBE_W = 16
) (
  input  logic [PROBE_W-1:0] probe,
  input  logic [PROBE_W-1:0] value,
  input  logic [PROBE_W-1:0] mask,
  input  logic               mode_ne,
  output logic               hit
);
  logic match;

  always_comb begin
    match = (((probe ^ value) & mask) == '0);
    hit   = mode_ne ? ~match : match;
  end
endmodule

// File: rtl/la_trig_combiner.sv
module la_trig_combiner
  import la_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  localparam int IW = $clog2(NUM_UNITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 step,
  input  logic [NUM_UNITS-1:0] hits,
  input  expr_op_e             op,
  input  logic [IW-1:0]        sel_a,
  input  logic [IW-1:0]        sel_b,
  input  logic                 inv_a,
  input  logic                 inv_b,
  output logic                 fire,
  output logic                 seq_first
);
  logic opnd_a;
  logic opnd_b;
  logic expr_true;

  always_comb begin
    opnd_a = hits[sel_a] ^ inv_a;
    opnd_b = hits[sel_b] ^ inv_b;
    unique case (op)
      OP_AND:  expr_true = opnd_a & opnd_b;
      OP_OR:   expr_true = opnd_a | opnd_b;
      OP_XOR:  expr_true = opnd_a ^ opnd_b;
      OP_THEN: expr_true = seq_first & opnd_b;
      default: expr_true = 1'b0;
    endcase
    fire = step & expr_true;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      seq_first <= 1'b0;
    end else if (step && (op == OP_THEN) && !seq_first && opnd_a) begin
      seq_first <= 1'b1;
    end
  end
endmodule

// File: rtl/la_capture_ram.sv
module la_capture_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/la_trigger_core.sv
module la_trigger_core
  import la_pkg::*;
#(
  parameter int PROBE_W   = 16,
  parameter int DEPTH     = 2048,
  parameter int NUM_UNITS = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int IW = $clog2(NUM_UNITS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           trig_en,
  input  logic                           sample_en,
  input  logic                           rearm,
  input  logic [PROBE_W-1:0]             probe,
  input  logic [NUM_UNITS*PROBE_W-1:0]   tu_value,
  input  logic [NUM_UNITS*PROBE_W-1:0]   tu_mask,
  input  logic [NUM_UNITS-1:0]           tu_ne,
  input  logic [1:0]                     expr_op,
  input  logic [IW-1:0]                  sel_a,
  input  logic [IW-1:0]                  sel_b,
  input  logic                           inv_a,
  input  logic                           inv_b,
  input  logic [AW-1:0]                  post_len,
  input  logic [AW-1:0]                  rd_addr,
  output logic [PROBE_W-1:0]             rd_data,
  output logic                           done,
  output logic                           triggered,
  output logic [AW-1:0]                  trig_addr
);
  cap_state_e           state;
  logic [AW-1:0]        wptr;
  logic [AW-1:0]        remain;
  logic [NUM_UNITS-1:0] hits;
  logic                 wr_en;
  logic                 eval_en;
  logic                 fire;
  logic                 seq_first;

  // one comparator per trigger unit
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    la_trig_unit #(.PROBE_W(PROBE_W)) u_unit (
      .probe   (probe),
      .value   (tu_value[u*PROBE_W +: PROBE_W]),
      .mask    (tu_mask[u*PROBE_W +: PROBE_W]),
      .mode_ne (tu_ne[u]),
      .hit     (hits[u])
    );
  end

  always_comb begin
    wr_en   = sample_en && !rearm && (state != ST_DONE);
    eval_en = sample_en && trig_en && !rearm && (state == ST_RUN);
  end

  la_trig_combiner #(.NUM_UNITS(NUM_UNITS)) u_comb (
    .clk       (clk),
    .rst       (rst),
    .clr       (rearm),
    .step      (eval_en),
    .hits      (hits),
    .op        (expr_op_e'(expr_op)),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .inv_a     (inv_a),
    .inv_b     (inv_b),
    .fire      (fire),
    .seq_first (seq_first)
  );

  la_capture_ram #(.DW(PROBE_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wptr),
    .wdata (probe),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_RUN;
      wptr      <= '0;
      remain    <= '0;
      done      <= 1'b0;
      triggered <= 1'b0;
      trig_addr <= '0;
    end else if (rearm) begin
      state     <= ST_RUN;
      remain    <= '0;
      done      <= 1'b0;
      triggered <= 1'b0;
    end else begin
      if (wr_en) begin
        wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      end
      unique case (state)
        ST_RUN: begin
          if (fire) begin
            triggered <= 1'b1;
            trig_addr <= wptr;
            if (post_len == '0) begin
              state <= ST_DONE;
              done  <= 1'b1;
            end else begin
              remain <= post_len;
              state  <= ST_POST;
            end
          end
        end
        ST_POST: begin
          if (sample_en) begin
            remain <= remain - 1'b1;
            if (remain == AW'(1)) begin
              state <= ST_DONE;
              done  <= 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/la_trigger_core_chk.sv
module la_trigger_core_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          trig_en,
  input logic          sample_en,
  input logic          rearm,
  input logic [1:0]    expr_op,
  input logic          seq_first,
  input logic [AW-1:0] wptr,
  input logic          done,
  input logic          triggered,
  input logic [AW-1:0] trig_addr
);
  p_idle_no_fire_r2: assert property (@(posedge clk) disable iff (rst)
    (!trig_en && !triggered) |=> !triggered);

  p_then_needs_first_r5: assert property (@(posedge clk) disable iff (rst)
    (expr_op == 2'd3 && !seq_first && !triggered) |=> !triggered);

  p_gap_no_advance_r6: assert property (@(posedge clk) disable iff (rst)
    !sample_en |=> $stable(wptr));

  p_gap_no_fire_r6: assert property (@(posedge clk) disable iff (rst)
    (!sample_en && !triggered) |=> !triggered);

  p_done_after_trig_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> triggered);

  p_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (done && !rearm) |=> (done && $stable(trig_addr) && $stable(wptr)));

  p_rearm_clears_r9: assert property (@(posedge clk) disable iff (rst)
    rearm |=> (!done && !triggered && !seq_first && $stable(wptr)));
endmodule

bind la_trigger_core la_trigger_core_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .trig_en   (trig_en),
  .sample_en (sample_en),
  .rearm     (rearm),
  .expr_op   (expr_op),
  .seq_first (seq_first),
  .wptr      (wptr),
  .done      (done),
  .triggered (triggered),
  .trig_addr (trig_addr)
);

// File: tb/la_trigger_core_tb.sv
`timescale 1ns/1ps
module la_trigger_core_tb;
  localparam int PW = 16;
  localparam int DEPTH = 2048;
  localparam int NU = 4;
  localparam int AW = $clog2(DEPTH);
  localparam int IW = $clog2(NU);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig_en = 1'b0, sample_en = 1'b0, rearm = 1'b0;
  logic [PW-1:0] probe = '0;
  logic [NU*PW-1:0] tu_value = '0, tu_mask = '0;
  logic [NU-1:0] tu_ne = '0;
  logic [1:0] expr_op = 2'd0;
  logic [IW-1:0] sel_a = '0, sel_b = '0;
  logic inv_a = 1'b0, inv_b = 1'b0;
  logic [AW-1:0] post_len = '0, rd_addr = '0;
  logic [PW-1:0] rd_data;
  logic done, triggered;
  logic [AW-1:0] trig_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference state
  logic [PW-1:0] m_mem [DEPTH];
  bit m_valid [DEPTH];
  int m_wptr = 0, m_state = 0, m_rem = 0, m_taddr = 0;
  bit m_seq = 0, m_trig = 0, m_done = 0;

  always #2 clk = ~clk;

  la_trigger_core #(.PROBE_W(PW), .DEPTH(DEPTH), .NUM_UNITS(NU)) u_dut (
    .clk(clk), .rst(rst), .trig_en(trig_en), .sample_en(sample_en), .rearm(rearm),
    .probe(probe), .tu_value(tu_value), .tu_mask(tu_mask), .tu_ne(tu_ne),
    .expr_op(expr_op), .sel_a(sel_a), .sel_b(sel_b), .inv_a(inv_a), .inv_b(inv_b),
    .post_len(post_len), .rd_addr(rd_addr), .rd_data(rd_data),
    .done(done), .triggered(triggered), .trig_addr(trig_addr)
  );

  function automatic bit m_hit(int u, logic [PW-1:0] p);
    logic [PW-1:0] v = tu_value[u*PW +: PW];
    logic [PW-1:0] m = tu_mask[u*PW +: PW];
    bit eq = (((p ^ v) & m) == '0);
    return tu_ne[u] ? !eq : eq;
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_status(string tag);
    cmp(tag, "done", int'(done), int'(m_done));
    cmp(tag, "triggered", int'(triggered), int'(m_trig));
    cmp(tag, "trig_addr", int'(trig_addr), m_taddr);
  endtask

  task automatic set_unit(int u, logic [PW-1:0] v, logic [PW-1:0] m, bit ne);
    tu_value[u*PW +: PW] = v;
    tu_mask[u*PW +: PW] = m;
    tu_ne[u] = ne;
  endtask

  // one clock: inputs driven at the falling edge, results sampled at the next one
  task automatic step(logic [PW-1:0] p, bit se, bit te, bit ra, string tag);
    bit a, b, fire, ok;
    int old;
    probe = p; sample_en = se; trig_en = te; rearm = ra;
    if (ra) begin
      m_state = 0; m_done = 0; m_trig = 0; m_seq = 0; m_rem = 0;
    end else begin
      a = m_hit(int'(sel_a), p) ^ inv_a;
      b = m_hit(int'(sel_b), p) ^ inv_b;
      ok = te && se && (m_state == 0);
      case (expr_op)
        2'd0: fire = a & b;
        2'd1: fire = a | b;
        2'd2: fire = a ^ b;
        default: fire = m_seq & b;
      endcase
      fire = fire & ok;
      old = m_wptr;
      if (se && m_state != 2) begin
        m_mem[old] = p; m_valid[old] = 1'b1;
        m_wptr = (old + 1) % DEPTH;
      end
      if (ok && expr_op == 2'd3 && !m_seq && a) m_seq = 1'b1;
      if (m_state == 0 && fire) begin
        m_trig = 1'b1; m_taddr = old;
        if (post_len == 0) begin m_state = 2; m_done = 1'b1; end
        else begin m_rem = int'(post_len); m_state = 1; end
      end else if (m_state == 1 && se) begin
        if (m_rem == 1) begin m_state = 2; m_done = 1'b1; end
        m_rem--;
      end
    end
    @(posedge clk);
    @(negedge clk);
    rearm = 1'b0;
    chk_status(tag);
  endtask

  task automatic rd_chk(int addr, string tag);
    int a = ((addr % DEPTH) + DEPTH) % DEPTH;
    if (!m_valid[a]) return;
    sample_en = 1'b0; trig_en = 1'b0; rearm = 1'b0;
    rd_addr = AW'(a);
    @(posedge clk);
    @(negedge clk);
    cmp(tag, "rd_data", int'(rd_data), int'(m_mem[a]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_valid[i] = 1'b0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk_status("R1");

    set_unit(0, 16'hA5A5, 16'hFFFF, 1'b0);
    set_unit(1, 16'h0030, 16'h00F0, 1'b0);
    set_unit(2, 16'h0000, 16'h8000, 1'b1);
    set_unit(3, 16'h1234, 16'hFFFF, 1'b1);

    // R2: matching samples while not armed
    expr_op = 2'd1; sel_a = 2'd0; sel_b = 2'd0; post_len = AW'(3);
    for (int i = 0; i < 4; i++) step(16'hA5A5, 1'b1, 1'b0, 1'b0, "R2");
    step(16'h0001, 1'b1, 1'b1, 1'b0, "R2");
    step(16'hA5A5, 1'b1, 1'b1, 1'b0, "R2");
    // R7: three post samples
    step(16'h0101, 1'b1, 1'b1, 1'b0, "R7");
    step(16'h0202, 1'b1, 1'b1, 1'b0, "R7");
    step(16'h0303, 1'b1, 1'b1, 1'b0, "R7");
    cmp("R7", "trig_addr_exp", int'(trig_addr), 5);
    for (int k = -1; k <= 4; k++) rd_chk(m_taddr + k, "R7");
    // R8: frozen after done
    for (int i = 0; i < 5; i++) step(16'h1111, 1'b1, 1'b1, 1'b0, "R8");
    for (int k = 0; k <= 4; k++) rd_chk(m_taddr + k, "R8");
    // R9
    step(16'h0, 1'b0, 1'b0, 1'b1, "R9");
    // R6: unqualified cycles
    for (int i = 0; i < 3; i++) step(16'hA5A5, 1'b0, 1'b1, 1'b0, "R6");
    step(16'h0007, 1'b1, 1'b1, 1'b0, "R6");
    rd_chk(m_wptr - 1, "R6");
    rd_chk(m_wptr - 2, "R6");

    // R4: AND, XOR with inversion, AND with inverted A
    post_len = '0;
    expr_op = 2'd0; sel_a = 2'd1; sel_b = 2'd2;
    step(16'h0030, 1'b1, 1'b1, 1'b0, "R4");
    step(16'h8030, 1'b1, 1'b1, 1'b0, "R4");
    step(16'h0, 1'b0, 1'b0, 1'b1, "R9");
    expr_op = 2'd2; inv_b = 1'b1;
    step(16'h0030, 1'b1, 1'b1, 1'b0, "R4");
    step(16'h0000, 1'b1, 1'b1, 1'b0, "R4");
    step(16'h0, 1'b0, 1'b0, 1'b1, "R9");
    expr_op = 2'd0; sel_a = 2'd3; inv_a = 1'b1; sel_b = 2'd1; inv_b = 1'b0;
    step(16'h1230, 1'b1, 1'b1, 1'b0, "R4");
    step(16'h1234, 1'b1, 1'b1, 1'b0, "R4");
    step(16'h0, 1'b0, 1'b0, 1'b1, "R9");

    // R5: sequence
    expr_op = 2'd3; sel_a = 2'd0; sel_b = 2'd2; inv_a = 1'b0; post_len = AW'(2);
    step(16'h8001, 1'b1, 1'b1, 1'b0, "R5");
    step(16'hA5A5, 1'b1, 1'b0, 1'b0, "R2");
    step(16'h8000, 1'b1, 1'b1, 1'b0, "R2");
    step(16'hA5A5, 1'b1, 1'b1, 1'b0, "R5");
    step(16'h8000, 1'b1, 1'b1, 1'b0, "R5");
    step(16'h4444, 1'b1, 1'b1, 1'b0, "R7");
    step(16'h5555, 1'b1, 1'b1, 1'b0, "R7");
    for (int k = 0; k <= 2; k++) rd_chk(m_taddr + k, "R5");
    step(16'h0, 1'b0, 1'b0, 1'b1, "R9");

    // R3: random configurations
    for (int r = 0; r < 40; r++) begin
      for (int u = 0; u < NU; u++)
        set_unit(u, PW'($urandom), PW'($urandom & $urandom & $urandom), 1'($urandom));
      expr_op = 2'($urandom); sel_a = IW'($urandom); sel_b = IW'($urandom);
      inv_a = 1'($urandom); inv_b = 1'($urandom); post_len = AW'($urandom % 5);
      step(16'h0, 1'b0, 1'b0, 1'b1, "R9");
      for (int s = 0; s < 30; s++) begin
        logic [PW-1:0] p = PW'($urandom);
        if ($urandom % 2 == 0) p = tu_value[($urandom % NU)*PW +: PW] ^ PW'($urandom % 4);
        step(p, 1'($urandom % 4 != 0), 1'($urandom % 8 != 0), 1'b0, "R3");
      end
      if (m_done) for (int k = 0; k < 3; k++) rd_chk(m_taddr + k, "R3");
    end

    // R10: wrap of the write pointer
    step(16'h0, 1'b0, 1'b0, 1'b1, "R9");
    for (int i = 0; i < DEPTH + 60; i++) step(PW'(i * 7 + 3), 1'b1, 1'b0, 1'b0, "R10");
    rd_chk(m_wptr - 1, "R10");
    rd_chk(m_wptr, "R10");
    rd_chk(0, "R10");
    rd_chk(DEPTH - 1, "R10");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule